// File: doc/BRIEF.md
# Active Message Launch Sequencer

This block turns one send command from a core into a train of 64-bit network flits. A message sits in one of two source stores: a small message register file that the core writes word by word, or a memory reached through a request/acknowledge read port. Word 0 of the message is the destination virtual address. Word 1 holds the handler selector and a size field. Any body words follow at consecutive locations. The sequencer reads these words one at a time and presents each one on a valid/ready flit output. It learns the length of the message from the size field of word 1 while the message is already in flight.

The core sees a `busy` level and a one-cycle `retire` pulse. The pulse comes once the last word of the message has been read out of its store. From that point the core may overwrite the message, even while the last flit is still waiting for the network. A send never waits for any reply. Once the last flit has been handed over, the next command is accepted at once. Register-file entries that are not rewritten keep their contents, so a following message can reuse the fields of an earlier one.

The control is a three-state machine:
- **IDLE**: waits for a command. IDLE→FETCH on `cmd_valid`.
- **FETCH**: reads the word at the current pointer. FETCH→SEND when the word arrives, which is at once for the register file and on `mem_ack` for memory.
- **SEND**: holds the flit valid. SEND→FETCH on `flit_ready` for a word that is not the last. SEND→IDLE on `flit_ready` for the last word.

Top module: `am_send_seq`

## Requirements
- R1: While reset is asserted and in the cycle after it is released, `busy`, `retire`, `flit_valid` and `mem_req` are all low.
- R2: A message is sent as 2+N flits in storage order: the destination word, the header word (selector in bits 7:0, N in bits 15:8, N counting 64-bit words), then N body words from locations base+2 through base+1+N. `flit_last` is high on the final flit only.
- R3: `cmd_src`=0 reads from the register file at index (base+i) mod RF_DEPTH, wrapping. `cmd_src`=1 reads from memory at address base+i. `mem_req` rises only for a memory-sourced message and holds `mem_addr` stable until `mem_ack`.
- R4: A size field of zero produces exactly two flits, the second of which carries `flit_last`.
- R5: While `flit_valid` is high and `flit_ready` is low, `flit_valid`, `flit_data` and `flit_last` hold their values. No word is skipped or repeated.
- R6: `busy` is high from the cycle after a command is taken until the last flit has been handed off. A command presented while `busy` is high is ignored and sends nothing.
- R7: Register-file entries keep their contents across sends. A later message carries the rewritten entries with their new values and the other entries unchanged.
- R8: `retire` is a one-cycle pulse, given exactly once per message. It is high in the first cycle in which the last word is presented as a flit, never earlier.
- R9: In the cycle after the last flit is taken, `busy` is low and a new command is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Send command, taken when not busy |
| cmd_src | input | 1 | 0 = register file, 1 = memory |
| cmd_base | input | MEM_AW | Location of message word 0 |
| busy | output | 1 | A message is in progress |
| retire | output | 1 | One-cycle pulse: all words have been read |
| rf_we | input | 1 | Register-file write enable |
| rf_widx | input | log2(RF_DEPTH) | Register-file write index |
| rf_wdata | input | DATA_W | Register-file write data |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | MEM_AW | Memory read address |
| mem_ack | input | 1 | Memory data valid this cycle |
| mem_rdata | input | DATA_W | Memory read data |
| flit_valid | output | 1 | Flit presented |
| flit_ready | input | 1 | Network takes the flit |
| flit_data | output | DATA_W | Flit word |
| flit_last | output | 1 | Final flit of the message |

## Verification
The bench drives messages of size zero, three, five and 255 words. These separate a length derived from the header field from an off-by-one in the count, and the largest size exercises the full counter width. Both source paths are tried: the register file with a message that wraps past the top index, and memory with zero and non-zero acknowledge delays. This separates correct pointer stepping from stepping that advances before the data arrives. Runs with the flit output always ready are set against runs with pseudo-random backpressure, which exposes skipped or repeated words. Further cases are a command pulsed mid-message, a back-to-back send, and a resend after one register entry has been rewritten; these show that refusal, release and field reuse behave as required.

// File: rtl/am_seq_pkg.sv
package am_seq_pkg;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_FETCH = 2'd1,
        SQ_SEND  = 2'd2
    } seq_state_t;

    typedef enum logic {
        SRC_RF  = 1'b0,
        SRC_MEM = 1'b1
    } src_sel_t;

    // header word layout (word 1 of a message)
    localparam int unsigned SEL_LSB   = 0;
    localparam int unsigned SEL_W     = 8;
    localparam int unsigned SIZE_LSB  = SEL_LSB + SEL_W;
    localparam int unsigned HDR_WORDS = 2;

endpackage

// File: rtl/am_msg_rf.sv
module am_msg_rf #(
    parameter int unsigned WORD_W = 64,
    parameter int unsigned DEPTH  = 16,
    localparam int unsigned IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wr_word,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [WORD_W-1:0] rd_word
);

    logic [WORD_W-1:0] slot [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            slot[wr_idx] <= wr_word;
        end
    end

    assign rd_word = slot[rd_idx];

endmodule

// File: rtl/am_word_fetch.sv
module am_word_fetch
    import am_seq_pkg::*;
#(
    parameter int unsigned WORD_W   = 64,
    parameter int unsigned ADDR_W   = 16,
    parameter int unsigned RF_IDX_W = 4
) (
    input  logic                fetch_en,
    input  src_sel_t            src,
    input  logic [ADDR_W-1:0]   ptr,
    output logic [RF_IDX_W-1:0] rf_idx,
    input  logic [WORD_W-1:0]   rf_word,
    output logic                mem_req,
    output logic [ADDR_W-1:0]   mem_addr,
    input  logic                mem_ack,
    input  logic [WORD_W-1:0]   mem_word,
    output logic                word_ok,
    output logic [WORD_W-1:0]   word
);

    always_comb begin
        rf_idx   = ptr[RF_IDX_W-1:0];
        mem_addr = ptr;
        mem_req  = 1'b0;
        word_ok  = 1'b0;
        word     = '0;
        unique case (src)
            SRC_RF: begin
                word_ok = fetch_en;
                word    = rf_word;
            end
            SRC_MEM: begin
                mem_req = fetch_en;
                word_ok = fetch_en && mem_ack;
                word    = mem_word;
            end
            default: begin
                word_ok = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/am_launch_fsm.sv
module am_launch_fsm
    import am_seq_pkg::*;
#(
    parameter int unsigned WORD_W = 64,
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned SIZE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  src_sel_t          cmd_src,
    input  logic [ADDR_W-1:0] cmd_base,
    output logic              fetch_en,
    output src_sel_t          fetch_src,
    output logic [ADDR_W-1:0] fetch_ptr,
    input  logic              word_ok,
    input  logic [WORD_W-1:0] word,
    output logic              flit_valid,
    input  logic              flit_ready,
    output logic [WORD_W-1:0] flit_data,
    output logic              flit_last,
    output logic              busy,
    output logic              retire
);

    localparam int unsigned IDX_W = SIZE_W + 2;

    seq_state_t        state_q, state_d;
    src_sel_t          src_q;
    logic [ADDR_W-1:0] ptr_q;
    logic [IDX_W-1:0]  idx_q;
    logic [SIZE_W-1:0] size_q;
    logic [WORD_W-1:0] data_q;
    logic              last_q;
    logic              retire_q;

    logic [SIZE_W-1:0] size_in;
    logic              cap_last;

    // length decision: word 1 carries the size, later words compare to it
    always_comb begin
        size_in = word[SIZE_LSB +: SIZE_W];
        if (idx_q == IDX_W'(1)) begin
            cap_last = (size_in == '0);
        end else begin
            cap_last = (idx_q >= IDX_W'(HDR_WORDS)) &&
                       (idx_q == IDX_W'(size_q) + IDX_W'(1));
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SQ_IDLE:  if (cmd_valid) state_d = SQ_FETCH;
            SQ_FETCH: if (word_ok)   state_d = SQ_SEND;
            SQ_SEND:  if (flit_ready) state_d = last_q ? SQ_IDLE : SQ_FETCH;
            default:  state_d = SQ_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs
    always_comb begin
        fetch_en   = (state_q == SQ_FETCH);
        fetch_src  = src_q;
        fetch_ptr  = ptr_q;
        flit_valid = (state_q == SQ_SEND);
        flit_data  = data_q;
        flit_last  = last_q;
        busy       = (state_q != SQ_IDLE);
        retire     = retire_q;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q    <= SRC_RF;
            ptr_q    <= '0;
            idx_q    <= '0;
            size_q   <= '0;
            data_q   <= '0;
            last_q   <= 1'b0;
            retire_q <= 1'b0;
        end else begin
            retire_q <= 1'b0;
            unique case (state_q)
                SQ_IDLE: begin
                    if (cmd_valid) begin
                        src_q  <= cmd_src;
                        ptr_q  <= cmd_base;
                        idx_q  <= '0;
                        last_q <= 1'b0;
                    end
                end
                SQ_FETCH: begin
                    if (word_ok) begin
                        data_q   <= word;
                        last_q   <= cap_last;
                        retire_q <= cap_last;
                        if (idx_q == IDX_W'(1)) begin
                            size_q <= size_in;
                        end
                    end
                end
                SQ_SEND: begin
                    if (flit_ready) begin
                        ptr_q <= ptr_q + ADDR_W'(1);
                        idx_q <= idx_q + IDX_W'(1);
                    end
                end
                default: begin
                    last_q <= 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/am_send_seq.sv
module am_send_seq
    import am_seq_pkg::*;
#(
    parameter int unsigned DATA_W   = 64,
    parameter int unsigned RF_DEPTH = 16,
    parameter int unsigned MEM_AW   = 16,
    parameter int unsigned SIZE_W   = 8,
    localparam int unsigned RF_IDX_W = $clog2(RF_DEPTH)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_valid,
    input  logic                cmd_src,
    input  logic [MEM_AW-1:0]   cmd_base,
    output logic                busy,
    output logic                retire,
    input  logic                rf_we,
    input  logic [RF_IDX_W-1:0] rf_widx,
    input  logic [DATA_W-1:0]   rf_wdata,
    output logic                mem_req,
    output logic [MEM_AW-1:0]   mem_addr,
    input  logic                mem_ack,
    input  logic [DATA_W-1:0]   mem_rdata,
    output logic                flit_valid,
    input  logic                flit_ready,
    output logic [DATA_W-1:0]   flit_data,
    output logic                flit_last
);

    logic                fetch_en;
    src_sel_t            fetch_src;
    logic [MEM_AW-1:0]   fetch_ptr;
    logic                word_ok;
    logic [DATA_W-1:0]   word;
    logic [RF_IDX_W-1:0] rf_ridx;
    logic [DATA_W-1:0]   rf_rword;

    am_msg_rf #(
        .WORD_W (DATA_W),
        .DEPTH  (RF_DEPTH)
    ) u_rf (
        .clk     (clk),
        .wr_en   (rf_we),
        .wr_idx  (rf_widx),
        .wr_word (rf_wdata),
        .rd_idx  (rf_ridx),
        .rd_word (rf_rword)
    );

    am_word_fetch #(
        .WORD_W   (DATA_W),
        .ADDR_W   (MEM_AW),
        .RF_IDX_W (RF_IDX_W)
    ) u_fetch (
        .fetch_en (fetch_en),
        .src      (fetch_src),
        .ptr      (fetch_ptr),
        .rf_idx   (rf_ridx),
        .rf_word  (rf_rword),
        .mem_req  (mem_req),
        .mem_addr (mem_addr),
        .mem_ack  (mem_ack),
        .mem_word (mem_rdata),
        .word_ok  (word_ok),
        .word     (word)
    );

    am_launch_fsm #(
        .WORD_W (DATA_W),
        .ADDR_W (MEM_AW),
        .SIZE_W (SIZE_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_src    (src_sel_t'(cmd_src)),
        .cmd_base   (cmd_base),
        .fetch_en   (fetch_en),
        .fetch_src  (fetch_src),
        .fetch_ptr  (fetch_ptr),
        .word_ok    (word_ok),
        .word       (word),
        .flit_valid (flit_valid),
        .flit_ready (flit_ready),
        .flit_data  (flit_data),
        .flit_last  (flit_last),
        .busy       (busy),
        .retire     (retire)
    );

endmodule

// File: rtl/am_send_seq_chk.sv
module am_send_seq_chk
    import am_seq_pkg::*;
#(
    parameter int unsigned DATA_W = 64,
    parameter int unsigned MEM_AW = 16,
    parameter int unsigned SIZE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              retire,
    input logic              mem_req,
    input logic [MEM_AW-1:0] mem_addr,
    input logic              mem_ack,
    input logic              flit_valid,
    input logic              flit_ready,
    input logic [DATA_W-1:0] flit_data,
    input logic              flit_last
);

    localparam int unsigned BW = SIZE_W + 2;

    logic [BW-1:0]     beat_q;
    logic [SIZE_W-1:0] size_seen_q;
    logic              len_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            beat_q      <= '0;
            size_seen_q <= '0;
        end else if (flit_valid && flit_ready) begin
            beat_q <= flit_last ? '0 : beat_q + BW'(1);
            if (beat_q == BW'(1)) begin
                size_seen_q <= flit_data[SIZE_LSB +: SIZE_W];
            end
        end
    end

    always_comb begin
        if (beat_q == BW'(1)) begin
            len_ok = (flit_data[SIZE_LSB +: SIZE_W] == '0);
        end else begin
            len_ok = (beat_q >= BW'(HDR_WORDS)) &&
                     (beat_q == BW'(size_seen_q) + BW'(1));
        end
    end

    assert_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
        flit_valid && flit_last |-> len_ok);

    assert_mem_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr));

    assert_mem_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);

    assert_flit_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        flit_valid && !flit_ready |=> flit_valid && $stable(flit_data) && $stable(flit_last));

    assert_valid_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        flit_valid |-> busy);

    assert_retire_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        retire |=> !retire);

    assert_retire_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
        retire |-> flit_valid && flit_last);

    assert_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flit_valid && flit_ready && flit_last |=> !busy);

endmodule

bind am_send_seq am_send_seq_chk #(
    .DATA_W (DATA_W),
    .MEM_AW (MEM_AW),
    .SIZE_W (SIZE_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .retire     (retire),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_ack    (mem_ack),
    .flit_valid (flit_valid),
    .flit_ready (flit_ready),
    .flit_data  (flit_data),
    .flit_last  (flit_last)
);

// File: tb/tb_am_send_seq.sv
`timescale 1ns/1ps
module tb_am_send_seq;

    localparam int DW = 64;
    localparam int MAW = 16;
    localparam int RFD = 16;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic           rst_n = 1'b0;
    logic           cmd_valid = 1'b0;
    logic           cmd_src = 1'b0;
    logic [MAW-1:0] cmd_base = '0;
    logic           busy, retire;
    logic           rf_we = 1'b0;
    logic [3:0]     rf_widx = '0;
    logic [DW-1:0]  rf_wdata = '0;
    logic           mem_req;
    logic [MAW-1:0] mem_addr;
    logic           mem_ack = 1'b0;
    logic [DW-1:0]  mem_rdata = '0;
    logic           flit_valid;
    logic           flit_ready = 1'b1;
    logic [DW-1:0]  flit_data;
    logic           flit_last;

    am_send_seq dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_src(cmd_src),
        .cmd_base(cmd_base), .busy(busy), .retire(retire), .rf_we(rf_we),
        .rf_widx(rf_widx), .rf_wdata(rf_wdata), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .flit_valid(flit_valid), .flit_ready(flit_ready),
        .flit_data(flit_data), .flit_last(flit_last)
    );

    int n_chk = 0;
    int n_fail = 0;
    logic [DW-1:0] rf_img [RFD];
    logic [DW-1:0] mem_img [256];
    logic [DW-1:0] exp_q [$];
    bit  busy_exp = 0;
    bit  cur_src = 0;
    int  retire_cnt = 0;
    int  msgs_done = 0;
    int  flit_idx = 0;
    int  last_len = 0;
    logic [DW-1:0] third_word = '0;
    int  mem_lat = 0;
    int  mem_cnt = 0;
    bit  bp_mode = 0;
    logic [7:0] lfsr = 8'hA5;
    logic pv = 1'b0;
    logic [DW-1:0] pd = '0;
    logic pl = 1'b0;
    int  cyc = 0;

    task automatic check(bit ok, string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] hdr(logic [7:0] sel, logic [7:0] sz);
        return {48'h0, sz, sel};
    endfunction

    // behavioural reference, evaluated every clock at the falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            bit b0;
            b0 = busy_exp;
            if (pv && flit_ready) begin
                if (exp_q.size() == 0) begin
                    check(0, "R2 unexpected flit", pd, '0);
                end else begin
                    logic [DW-1:0] e;
                    e = exp_q.pop_front();
                    check(pd == e, "R2 flit data", pd, e);
                    check(pl == (exp_q.size() == 0), "R2 flit_last", DW'(pl), DW'(exp_q.size() == 0));
                    if (flit_idx == 2) third_word = pd;
                    flit_idx++;
                    if (exp_q.size() == 0) begin
                        busy_exp = 0;
                        check(retire_cnt == 1, "R8 retire once", DW'(retire_cnt), 1);
                        last_len = flit_idx;
                        msgs_done++;
                    end
                end
            end
            if (pv && !flit_ready) begin
                check(flit_valid && flit_data == pd && flit_last == pl, "R5 hold under backpressure", flit_data, pd);
            end
            if (cmd_valid && !b0) begin
                logic [DW-1:0] h1;
                int sz;
                if (cmd_src) h1 = mem_img[(int'(cmd_base) + 1) % 256];
                else         h1 = rf_img[(int'(cmd_base) + 1) % RFD];
                sz = int'(h1[15:8]);
                for (int i = 0; i < sz + 2; i++) begin
                    if (cmd_src) exp_q.push_back(mem_img[(int'(cmd_base) + i) % 256]);
                    else         exp_q.push_back(rf_img[(int'(cmd_base) + i) % RFD]);
                end
                busy_exp = 1;
                cur_src = cmd_src;
                retire_cnt = 0;
                flit_idx = 0;
            end
            check(busy == busy_exp, "R6 busy level", DW'(busy), DW'(busy_exp));
            if (retire) begin
                retire_cnt++;
                check(flit_valid && flit_last && exp_q.size() == 1, "R8 retire timing",
                      DW'({flit_valid, flit_last}), 64'h3);
            end
            if (mem_req) check(cur_src == 1, "R3 mem_req only for memory source", DW'(cur_src), 1);
            pv = flit_valid;
            pd = flit_data;
            pl = flit_last;
        end
    end

    // memory responder with programmable acknowledge delay
    always @(negedge clk) begin
        #1;
        if (!mem_req) begin
            mem_ack = 1'b0;
            mem_cnt = 0;
        end else if (mem_cnt >= mem_lat) begin
            mem_ack = 1'b1;
            mem_rdata = mem_img[mem_addr[7:0]];
            mem_cnt = 0;
        end else begin
            mem_ack = 1'b0;
            mem_cnt++;
        end
    end

    // network side ready
    always @(negedge clk) begin
        #1;
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        flit_ready = bp_mode ? lfsr[0] : 1'b1;
    end

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++;
            n_fail++;
            $display("FAIL R6 watchdog expired actual=%0d expected<150000", cyc);
            summary();
            $finish;
        end
    end

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic rf_wr(int idx, logic [DW-1:0] val);
        rf_we = 1'b1;
        rf_widx = 4'(idx);
        rf_wdata = val;
        rf_img[idx] = val;
        step();
        rf_we = 1'b0;
    endtask

    task automatic send(bit src, int base);
        while (busy_exp) step();
        cmd_src = src;
        cmd_base = MAW'(base);
        cmd_valid = 1'b1;
        step();
        cmd_valid = 1'b0;
    endtask

    task automatic wait_done();
        while (busy_exp || exp_q.size() != 0) step();
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem_img[i] = {32'hC0DE0000 | 32'(i), ~32'(i)};
        for (int i = 0; i < RFD; i++) rf_img[i] = '0;
        repeat (3) step();
        // R1: reset state
        check(!busy && !retire && !flit_valid && !mem_req, "R1 reset outputs",
              DW'({busy, retire, flit_valid, mem_req}), '0);
        rst_n = 1'b1;
        step();
        check(!busy && !flit_valid && !mem_req, "R1 after release",
              DW'({busy, flit_valid, mem_req}), '0);

        for (int i = 0; i < RFD; i++) rf_wr(i, 64'h1111_0000_0000_0000 | 64'(i));

        // R4: size zero from the register file
        rf_wr(0, 64'hFEED_0000_0000_1000);
        rf_wr(1, hdr(8'h21, 8'd0));
        send(0, 0);
        wait_done();
        check(last_len == 2, "R4 header-only length", DW'(last_len), 2);

        // R2: size three, always ready
        rf_wr(4, 64'hFEED_0000_0000_2000);
        rf_wr(5, hdr(8'h07, 8'd3));
        send(0, 4);
        wait_done();
        check(last_len == 5, "R2 message length", DW'(last_len), 5);

        // R3/R5: size five wrapping the register file, with backpressure
        bp_mode = 1;
        rf_wr(10, 64'hFEED_0000_0000_3000);
        rf_wr(11, hdr(8'h3C, 8'd5));
        send(0, 10);
        wait_done();
        check(last_len == 7, "R3 wrap length", DW'(last_len), 7);

        // R6: command pulsed while busy is ignored
        send(0, 4);
        step();
        step();
        cmd_src = 1'b1;
        cmd_base = 16'd40;
        cmd_valid = 1'b1;
        step();
        cmd_valid = 1'b0;
        wait_done();
        repeat (10) step();
        check(!busy && !flit_valid && msgs_done == 4, "R6 refused command sends nothing",
              DW'(msgs_done), 4);
        bp_mode = 0;

        // R7: rewrite a single body entry, resend
        rf_wr(6, 64'hABCD_EF01_2345_6789);
        send(0, 4);
        wait_done();
        check(third_word == 64'hABCD_EF01_2345_6789, "R7 rewritten field", third_word, 64'hABCD_EF01_2345_6789);

        // R9: immediate back-to-back send
        check(!busy, "R9 released after last flit", DW'(busy), 0);
        send(0, 0);
        wait_done();
        check(last_len == 2, "R9 second send accepted", DW'(last_len), 2);

        // R3: memory source with delay
        mem_lat = 3;
        mem_img[33] = hdr(8'h55, 8'd4);
        send(1, 32);
        wait_done();
        check(last_len == 6, "R3 memory message length", DW'(last_len), 6);

        // R4: memory, size zero, backpressure, no delay
        mem_lat = 0;
        bp_mode = 1;
        mem_img[101] = hdr(8'h99, 8'd0);
        send(1, 100);
        wait_done();
        check(last_len == 2, "R4 memory header-only", DW'(last_len), 2);

        // R2: largest size from memory
        bp_mode = 0;
        mem_lat = 1;
        mem_img[1] = hdr(8'hEE, 8'd255);
        send(1, 0);
        wait_done();
        check(last_len == 257, "R2 maximum size", DW'(last_len), 257);

        repeat (4) step();
        summary();
        $finish;
    end

endmodule